// File: doc/BRIEF.md
# Per-Line GPIO Interrupt Controller

This block turns up to 32 already-synchronized (or debounced) input lines into interrupt requests. Each line is configured on its own: detection can be level-sensitive or edge-sensitive with a chosen polarity, or dual-edge, which reacts to both transitions. Each line also has an enable and a mask. Edge events are held in a per-line latch until software acknowledges them by writing an end-of-interrupt bit. Level lines are never latched; they report the sampled input as it is.

Software reaches the block through a simple 32-bit register bus with a write strobe, a byte address and combinational read data. Every per-line setting has a set address and a clear address: a 1 in a data bit changes that line, and a 0 leaves it as it was. Pending lines that are not masked appear in a status word. The status bits are OR-ed into one interrupt output, and a global combine-enable bit gates that output.

Top module: `line_irq_unit`

## Requirements
- R1: After reset every per-line setting and the combine-enable are 0, the status word (address 0x070), the dual-edge readback (0x0B8) and the combine readback (0x0A0) read 0, and `irq` is low.
- R2: The settings use write-one set/clear pairs: enable 0x020/0x024, mask 0x030/0x034, edge-type 0x040/0x044, polarity 0x050/0x054, dual-edge 0x0B0/0x0B4. Data bit i addresses line i. A 0 bit leaves that line's setting unchanged.
- R3: A line that is enabled, in edge mode (edge-type bit 1) and not dual-edge latches an event when two consecutive input samples differ in the direction its polarity selects (1 = rising, 0 = falling). The latched bit shows in the status word one clock after the sample that carries the new level, and it stays there after the input returns.
- R4: A dual-edge line latches on both rising and falling transitions, whatever its edge-type and polarity bits say.
- R5: A line in level mode (edge-type 0, not dual-edge) that is enabled shows as pending while its sampled input equals its polarity bit (1 = active-high, 0 = active-low). Nothing is latched.
- R6: Writing 1 to bit i of address 0x078 clears line i's latched edge. On a level-mode line the write has no effect.
- R7: When a new edge on a line and an end-of-interrupt write to that line fall in the same cycle, the line stays pending.
- R8: A masked line is left out of the status word and out of `irq`, but its latched edge is kept and shows again once the line is unmasked.
- R9: A disabled line shows nothing and detects no edges. Clearing its enable discards any latched edge, so it is not pending when the line is re-enabled.
- R10: `irq` is high exactly when bit 0 of the combine register (address 0x0A0, read back at the same address) is 1 and the status word is nonzero.
- R11: Address 0x0B8 reads back the dual-edge setting of every line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data, bit i for line i |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| line_in | input | 32 | Synchronized line inputs |
| irq | output | 1 | Merged interrupt request |

## Verification
The collision that matters is a fresh edge on a line in the same clock as an end-of-interrupt write that clears it. The bench forces this in a directed step: it drives a falling transition on an armed falling-edge line while it writes that line's acknowledge bit, and it expects the status bit to stay set. It then repeats the plain acknowledge and expects the bit to drop. The random phase also lets toggling inputs and acknowledge writes overlap freely, and the bench checks every cycle against a cycle model written from the requirements.

// File: rtl/line_irq_pkg.sv
// Package: register offsets shared by the interrupt controller and its checker.
// Assumes byte addresses on a bus with 32-bit words.
package line_irq_pkg;
    localparam int OFS_EN_SET   = 'h020;
    localparam int OFS_EN_CLR   = 'h024;
    localparam int OFS_MSK_SET  = 'h030;
    localparam int OFS_MSK_CLR  = 'h034;
    localparam int OFS_EDG_SET  = 'h040;
    localparam int OFS_EDG_CLR  = 'h044;
    localparam int OFS_POL_SET  = 'h050;
    localparam int OFS_POL_CLR  = 'h054;
    localparam int OFS_STATUS   = 'h070;
    localparam int OFS_ACK      = 'h078;
    localparam int OFS_COMB     = 'h0A0;
    localparam int OFS_DUAL_SET = 'h0B0;
    localparam int OFS_DUAL_CLR = 'h0B4;
    localparam int OFS_DUAL_RD  = 'h0B8;
endpackage

// File: rtl/line_irq_regs.sv
// Module: configuration registers for the line interrupt controller.
// Holds the per-line set/clear settings and the combine-enable, turns acknowledge
// writes into a one-cycle pulse vector, and muxes read data by address.
// Assumes NLINES <= DATA_W and that bus_rdata is sampled combinationally.
module line_irq_regs
    import line_irq_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [NLINES-1:0] status_in,
    output logic [NLINES-1:0] en_q,
    output logic [NLINES-1:0] msk_q,
    output logic [NLINES-1:0] edg_q,
    output logic [NLINES-1:0] pol_q,
    output logic [NLINES-1:0] dual_q,
    output logic              comb_q,
    output logic [NLINES-1:0] ack_vec,
    output logic [DATA_W-1:0] bus_rdata
);
    localparam logic [NLINES-1:0] NONE = '0;

    logic [NLINES-1:0] wbits;
    assign wbits = bus_wdata[NLINES-1:0];

    // Write strobe for one register offset.
    function automatic logic hit(input int ofs);
        return bus_wr && (bus_addr == ADDR_W'(ofs));
    endfunction

    // Next value of a set/clear register pair: ones set bits, ones clear bits.
    function automatic logic [NLINES-1:0] sc_next(input logic [NLINES-1:0] cur,
                                                 input int set_ofs, input int clr_ofs);
        logic [NLINES-1:0] s, c;
        s = hit(set_ofs) ? wbits : NONE;
        c = hit(clr_ofs) ? wbits : NONE;
        return (cur | s) & ~c;
    endfunction

    // Update the per-line settings and the combine-enable bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            msk_q  <= '0;
            edg_q  <= '0;
            pol_q  <= '0;
            dual_q <= '0;
            comb_q <= 1'b0;
        end else begin
            en_q   <= sc_next(en_q,   OFS_EN_SET,   OFS_EN_CLR);
            msk_q  <= sc_next(msk_q,  OFS_MSK_SET,  OFS_MSK_CLR);
            edg_q  <= sc_next(edg_q,  OFS_EDG_SET,  OFS_EDG_CLR);
            pol_q  <= sc_next(pol_q,  OFS_POL_SET,  OFS_POL_CLR);
            dual_q <= sc_next(dual_q, OFS_DUAL_SET, OFS_DUAL_CLR);
            if (hit(OFS_COMB)) comb_q <= bus_wdata[0];
        end
    end

    // Acknowledge pulses last only for the write cycle.
    always_comb ack_vec = hit(OFS_ACK) ? wbits : NONE;

    // Read data selected by address; unknown addresses read zero.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_STATUS))       bus_rdata[NLINES-1:0] = status_in;
        else if (bus_addr == ADDR_W'(OFS_DUAL_RD)) bus_rdata[NLINES-1:0] = dual_q;
        else if (bus_addr == ADDR_W'(OFS_COMB))    bus_rdata[0] = comb_q;
    end
endmodule

// File: rtl/line_irq_cell.sv
// Module: detector for one line.
// Samples the input once per clock, finds edges against the previous sample,
// keeps the edge latch and produces the line's pending flag.
// Assumes din is already synchronous to clk.
module line_irq_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    input  logic en,
    input  logic edg,
    input  logic pol,
    input  logic dual,
    input  logic ack,
    output logic evt,
    output logic lat,
    output logic pend
);
    logic prev_q;
    logic lat_q;
    logic rise, fall, edge_mode;

    // Keep the previous input sample.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= din;
    end

    // Classify the transition and qualify it by mode and enable.
    always_comb begin
        rise      = din & ~prev_q;
        fall      = ~din & prev_q;
        edge_mode = dual | edg;
        if (dual) evt = en & (rise | fall);
        else      evt = en & edg & (pol ? rise : fall);
    end

    // Edge latch: the new event beats the acknowledge; disable or level mode empties it.
    always_ff @(posedge clk) begin
        if (!rst_n)               lat_q <= 1'b0;
        else if (!en || !edge_mode) lat_q <= 1'b0;
        else if (evt)             lat_q <= 1'b1;
        else if (ack)             lat_q <= 1'b0;
    end

    assign lat  = lat_q;
    assign pend = en & (lat_q | (~edge_mode & (prev_q == pol)));
endmodule

// File: rtl/line_irq_merge.sv
// Module: applies the per-line mask and merges the lines into one request.
// Purely combinational; assumes its inputs come from registers.
module line_irq_merge #(
    parameter int NLINES = 32
) (
    input  logic [NLINES-1:0] pend,
    input  logic [NLINES-1:0] msk,
    input  logic              comb_en,
    output logic [NLINES-1:0] status,
    output logic              irq
);
    // Visible status and gated OR.
    always_comb begin
        status = pend & ~msk;
        irq    = comb_en & (|status);
    end
endmodule

// File: rtl/line_irq_unit.sv
// Module: top of the per-line interrupt controller.
// Connects the register block, one detector per line and the merge stage.
// Assumes line_in is synchronized or debounced outside this block.
module line_irq_unit #(
    parameter int NLINES = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NLINES-1:0] line_in,
    output logic              irq
);
    logic [NLINES-1:0] en_q, msk_q, edg_q, pol_q, dual_q, ack_vec;
    logic [NLINES-1:0] edge_evt, edge_lat, pend_vec, status_vec;
    logic              comb_q;

    line_irq_regs #(.NLINES(NLINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .status_in(status_vec),
        .en_q(en_q), .msk_q(msk_q), .edg_q(edg_q), .pol_q(pol_q),
        .dual_q(dual_q), .comb_q(comb_q), .ack_vec(ack_vec), .bus_rdata(bus_rdata)
    );

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        line_irq_cell u_cell (
            .clk(clk), .rst_n(rst_n), .din(line_in[i]), .en(en_q[i]),
            .edg(edg_q[i]), .pol(pol_q[i]), .dual(dual_q[i]), .ack(ack_vec[i]),
            .evt(edge_evt[i]), .lat(edge_lat[i]), .pend(pend_vec[i])
        );
    end

    line_irq_merge #(.NLINES(NLINES)) u_merge (
        .pend(pend_vec), .msk(msk_q), .comb_en(comb_q),
        .status(status_vec), .irq(irq)
    );
endmodule

// File: rtl/line_irq_checker.sv
// Module: temporal checks on the edge latches, bound into line_irq_unit.
// Assumes the bound names en_q, edg_q, pol_q, dual_q, edge_evt and edge_lat.
module line_irq_checker
    import line_irq_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NLINES-1:0] line_in,
    input logic [NLINES-1:0] en_vec,
    input logic [NLINES-1:0] edg_vec,
    input logic [NLINES-1:0] pol_vec,
    input logic [NLINES-1:0] dual_vec,
    input logic [NLINES-1:0] evt_vec,
    input logic [NLINES-1:0] lat_vec
);
    logic [NLINES-1:0] arm_rise;
    assign arm_rise = en_vec & edg_vec & pol_vec & ~dual_vec;

    AST_RISE_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        ((lat_vec & $past(arm_rise) & $past(line_in) & ~$past(line_in, 2)) ==
         ($past(arm_rise) & $past(line_in) & ~$past(line_in, 2)))); // R3

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_ACK)) |=>
        ((lat_vec & $past(bus_wdata[NLINES-1:0] & ~evt_vec)) == '0)); // R6

    AST_EDGE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec != '0) |=> ((lat_vec & $past(evt_vec)) == $past(evt_vec))); // R7

    AST_DISABLE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        ((lat_vec & ~$past(en_vec)) == '0)); // R9
endmodule

bind line_irq_unit line_irq_checker #(.NLINES(NLINES), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .line_in(line_in), .en_vec(en_q), .edg_vec(edg_q),
    .pol_vec(pol_q), .dual_vec(dual_q), .evt_vec(edge_evt), .lat_vec(edge_lat)
);

// File: tb/line_irq_unit_test.sv
module line_irq_unit_test;
    localparam int CLK_NS = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h70;
    logic [31:0] bus_wdata = '0;
    logic [31:0] line_in = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // Model state, updated from the requirements.
    logic [31:0] m_en = 0, m_msk = 0, m_edg = 0, m_pol = 0, m_dual = 0, m_prev = 0, m_lat = 0;
    logic        m_comb = 0;

    line_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in), .irq(irq)
    );

    always #(CLK_NS/2) clk = ~clk;

    function automatic logic [31:0] m_status();
        logic [31:0] lvl;
        lvl = ~(m_dual | m_edg) & ~(m_prev ^ m_pol);
        return m_en & (m_lat | lvl) & ~m_msk;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        bus_wr = 1'b0;
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    // One clock: drive inputs at the falling edge, advance the model, land on the next falling edge.
    task automatic tick(input bit w, input logic [7:0] a, input logic [31:0] d, input logic [31:0] din);
        logic [31:0] ack, rise, fall, evt, nlat;
        bus_wr = w; bus_addr = a; bus_wdata = d; line_in = din;
        ack  = (w && a == 8'h78) ? d : 32'h0;
        rise = din & ~m_prev;
        fall = ~din & m_prev;
        evt  = m_en & ((m_dual & (rise | fall)) |
                       (~m_dual & m_edg & ((m_pol & rise) | (~m_pol & fall))));
        nlat = m_en & (m_dual | m_edg) & (evt | (m_lat & ~ack));
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        m_lat = nlat;
        m_prev = din;
        if (w) begin
            case (a)
                8'h20: m_en = m_en | d;     8'h24: m_en = m_en & ~d;
                8'h30: m_msk = m_msk | d;   8'h34: m_msk = m_msk & ~d;
                8'h40: m_edg = m_edg | d;   8'h44: m_edg = m_edg & ~d;
                8'h50: m_pol = m_pol | d;   8'h54: m_pol = m_pol & ~d;
                8'hB0: m_dual = m_dual | d; 8'hB4: m_dual = m_dual & ~d;
                8'hA0: m_comb = d[0];
                default: ;
            endcase
        end
    endtask

    task automatic exp_st(input string req, input logic [31:0] exp, input logic exp_irq);
        logic [31:0] v;
        rd(8'h70, v);
        chk(req, v, exp);
        chk({req, " irq"}, {31'h0, irq}, {31'h0, exp_irq});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_NS * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] din;
        void'($urandom(32'd1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        exp_st("R1 status", 32'h0, 1'b0);
        rd(8'hB8, v); chk("R1 dual readback", v, 32'h0);
        rd(8'hA0, v); chk("R1 combine readback", v, 32'h0);
        // Configure: line0 rising edge, line1 falling edge, line2 level high, line3 level low.
        tick(1, 8'h50, 32'h5, 0);
        tick(1, 8'h40, 32'h3, 0);
        tick(1, 8'hA0, 32'h1, 0);
        tick(1, 8'h20, 32'hF, 0);
        exp_st("R5 active-low idle", 32'h8, 1'b1);
        rd(8'hA0, v); chk("R10 combine readback", v, 32'h1);
        tick(0, 8'h70, 0, 32'h1);
        exp_st("R3 rising latched", 32'h9, 1'b1);
        tick(0, 8'h70, 0, 32'h0);
        exp_st("R3 latch holds", 32'h9, 1'b1);
        tick(1, 8'h78, 32'h9, 32'h0);
        exp_st("R6 ack edge, level untouched", 32'h8, 1'b1);
        tick(0, 8'h70, 0, 32'h2);
        exp_st("R3 falling line ignores rise", 32'h8, 1'b1);
        tick(0, 8'h70, 0, 32'h0);
        exp_st("R3 falling latched", 32'hA, 1'b1);
        tick(0, 8'h70, 0, 32'hC);
        exp_st("R5 level follows high", 32'h6, 1'b1);
        tick(0, 8'h70, 0, 32'h0);
        exp_st("R5 level follows low", 32'hA, 1'b1);
        tick(0, 8'h70, 0, 32'h2);
        tick(1, 8'h78, 32'h2, 32'h0);
        exp_st("R7 edge beats ack", 32'hA, 1'b1);
        tick(1, 8'h78, 32'h2, 32'h0);
        exp_st("R6 plain ack", 32'h8, 1'b1);
        tick(0, 8'h70, 0, 32'h1);
        exp_st("R3 rise again", 32'h9, 1'b1);
        tick(1, 8'h30, 32'h1, 32'h1);
        exp_st("R8 masked hidden", 32'h8, 1'b1);
        tick(1, 8'h34, 32'h1, 32'h1);
        exp_st("R8 latch kept", 32'h9, 1'b1);
        tick(1, 8'h30, 32'hF, 32'h1);
        exp_st("R8 all masked", 32'h0, 1'b0);
        tick(1, 8'h34, 32'hF, 32'h1);
        tick(1, 8'hA0, 32'h0, 32'h1);
        exp_st("R10 combine gate off", 32'h9, 1'b0);
        rd(8'hA0, v); chk("R10 combine readback off", v, 32'h0);
        tick(1, 8'hA0, 32'h1, 32'h1);
        exp_st("R10 combine gate on", 32'h9, 1'b1);
        tick(1, 8'h24, 32'h1, 32'h1);
        exp_st("R9 disable hides", 32'h8, 1'b1);
        tick(0, 8'h70, 0, 32'h0);
        tick(0, 8'h70, 0, 32'h1);
        tick(1, 8'h20, 32'h1, 32'h1);
        exp_st("R9 edge discarded and ignored", 32'h8, 1'b1);
        tick(1, 8'hB0, 32'h2, 32'h1);
        rd(8'hB8, v); chk("R11 dual readback", v, 32'h2);
        tick(0, 8'h70, 0, 32'h3);
        exp_st("R4 dual rise on falling line", 32'hA, 1'b1);
        tick(1, 8'h78, 32'h2, 32'h3);
        tick(0, 8'h70, 0, 32'h1);
        exp_st("R4 dual fall", 32'hA, 1'b1);
        tick(1, 8'h78, 32'h2, 32'h1);
        tick(1, 8'hB0, 32'h4, 32'h1);
        tick(1, 8'hB4, 32'h2, 32'h1);
        rd(8'hB8, v); chk("R2 clear one bit only", v, 32'h4);
        tick(1, 8'hB4, 32'h4, 32'h1);
        exp_st("R2 settled", 32'h8, 1'b1);
        // Random phase against the model.
        din = 32'h1;
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] a;
            logic [31:0] d;
            bit w;
            din = din ^ ($urandom & $urandom & $urandom);
            w = ($urandom % 3) == 0;
            case ($urandom % 13)
                0: a = 8'h20;  1: a = 8'h24;  2: a = 8'h30;  3: a = 8'h34;
                4: a = 8'h40;  5: a = 8'h44;  6: a = 8'h50;  7: a = 8'h54;
                8: a = 8'hB0;  9: a = 8'hB4;  10: a = 8'hA0;
                default: a = 8'h78;
            endcase
            d = (a == 8'hA0) ? (($urandom % 4) != 0 ? 32'h1 : 32'h0) : ($urandom & $urandom);
            tick(w, a, d, din);
            exp_st("R3/R4/R5/R6/R7/R8/R9 random status", m_status(), m_comb & (|m_status()));
            rd(8'hB8, v); chk("R11 random dual readback", v, m_dual);
            rd(8'hA0, v); chk("R10 random combine readback", v, {31'h0, m_comb});
        end
        finish_run();
    end
endmodule